// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Status Unit

This block holds the interrupt flags of a real-time clock. Three event sources pulse for one clock cycle each: an edge on the chosen divider tap (periodic), a match between current time and alarm time (alarm), and the end of an update cycle (update). Each pulse sets a sticky flag, whether or not that source's enable is set. The unit also takes a parameterised number of extended-source flags, which are held outside, each with its own enable.

A request bit is the OR of every flag ANDed with its enable. An active-low interrupt pin follows the request bit without delay. Software reads two bytes through a small read port. The first is the status byte, which carries the request bit and the three sticky flags. The second is the battery byte, which carries a valid-RAM-and-time indication. Reading the status byte clears the three sticky flags. Reading the battery byte clears nothing.

Top module: `rtc_irq_status`

## Requirements
- R1: The status byte (rd_sel = 0) carries the request bit in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3..0 always read 0.
- R2: The request bit equals (periodic flag & en_periodic) | (alarm flag & en_alarm) | (update flag & en_update) | OR over i of (ext_flag[i] & ext_en[i]).
- R3: irq_n is 0 whenever the request bit is 1 and 1 otherwise. It follows the flag and enable values in the same cycle, so clearing an enable releases irq_n at once and leaves the flag set.
- R4: A pulse on evt_periodic, evt_alarm or evt_update sets the matching flag on the next rising clock edge, whatever the value of its enable.
- R5: A status read (rd_en = 1, rd_sel = 0) returns the flag values from before the clear. The three sticky flags read 0 after the next rising edge.
- R6: If an event pulse arrives in the same cycle as a clearing status read, the flag for that event is 1 after the edge.
- R7: A status read does not change ext_flag. A request that comes from an enabled extended flag stays asserted after the read.
- R8: The battery byte (rd_sel = 1) carries vrt_in in bit 7 and 0 in bits 6..0. Reading it leaves every flag unchanged.
- R9: While rst_n is low, all three sticky flags are 0. With all extended flags disabled or low, irq_n is then 1 and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | Single-cycle divider-tap edge pulse |
| evt_alarm | input | 1 | Single-cycle alarm match pulse |
| evt_update | input | 1 | Single-cycle update-ended pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| ext_flag | input | NUM_EXT | Externally held extended-source flags |
| ext_en | input | NUM_EXT | Enables for the extended flags |
| vrt_in | input | 1 | Valid RAM and time indication |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Byte select: 0 for status, 1 for battery |
| rd_data | output | DATA_W | Selected byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two cases are hard to reach from the ports. In the first, an event pulse lands in exactly the cycle of a clearing read. In the second, an enable drops while its flag is still set. The directed stimulus first sets the periodic flag. It then drives an alarm pulse together with a status read strobe at the same falling edge, and checks that the periodic flag cleared while the alarm flag survived. For the enable case, the bench sets the update flag with its enable on, waits for irq_n to go low, and then lowers only the enable. It checks irq_n one time step later, and checks through the status byte that the flag is still 1.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int unsigned NUM_EVT = 3;
   // bit index of each sticky flag inside the event vector
   localparam int unsigned IDX_UPD = 0;
   localparam int unsigned IDX_ALM = 1;
   localparam int unsigned IDX_PER = 2;
   typedef enum logic {SEL_STATUS = 1'b0, SEL_BATT = 1'b1} rd_sel_e;
endpackage

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_rise_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/rtc_irq_req.sv
module rtc_irq_req #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] flag_i,
   input  logic [N-1:0] en_i,
   output logic         req_o,
   output logic         irq_n_o
);
   logic [N-1:0] term;
   always_comb begin
      term    = flag_i & en_i;
      req_o   = |term;
      irq_n_o = ~req_o;
   end
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_EVT = 3
) (
   input  logic               sel_i,
   input  logic               req_i,
   input  logic [NUM_EVT-1:0] flags_i,
   input  logic               vrt_i,
   output logic [DATA_W-1:0]  data_o
);
   localparam int unsigned PAD_STAT = DATA_W - 1 - NUM_EVT;
   localparam int unsigned PAD_BATT = DATA_W - 1;

   logic [DATA_W-1:0] stat_byte;
   logic [DATA_W-1:0] batt_byte;

   always_comb begin
      stat_byte = {req_i, flags_i, {PAD_STAT{1'b0}}};
      batt_byte = {vrt_i, {PAD_BATT{1'b0}}};
      data_o    = sel_i ? batt_byte : stat_byte;
   end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
   import rtc_irq_pkg::*;
#(
   parameter int unsigned NUM_EXT = 3,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_periodic,
   input  logic               evt_alarm,
   input  logic               evt_update,
   input  logic               en_periodic,
   input  logic               en_alarm,
   input  logic               en_update,
   input  logic [NUM_EXT-1:0] ext_flag,
   input  logic [NUM_EXT-1:0] ext_en,
   input  logic               vrt_in,
   input  logic               rd_en,
   input  logic               rd_sel,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq_n
);
   localparam int unsigned N_TERMS = NUM_EVT + NUM_EXT;

   if (DATA_W < NUM_EVT + 1) begin : g_bad_width
      $error("rtc_irq_status: DATA_W too small for the status byte");
   end
   if (NUM_EXT < 1) begin : g_bad_ext
      $error("rtc_irq_status: NUM_EXT must be at least 1");
   end

   logic [NUM_EVT-1:0] evt_vec;
   logic [NUM_EVT-1:0] en_vec;
   logic [NUM_EVT-1:0] flag_q;
   logic               clr_rd;
   logic               req;

   always_comb begin
      evt_vec          = '0;
      en_vec           = '0;
      evt_vec[IDX_PER] = evt_periodic;
      evt_vec[IDX_ALM] = evt_alarm;
      evt_vec[IDX_UPD] = evt_update;
      en_vec[IDX_PER]  = en_periodic;
      en_vec[IDX_ALM]  = en_alarm;
      en_vec[IDX_UPD]  = en_update;
      clr_rd           = rd_en && (rd_sel == SEL_STATUS);
   end

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
      rtc_evt_flag flag_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (evt_vec[i]),
         .clr_i  (clr_rd),
         .flag_o (flag_q[i])
      );
   end

   rtc_irq_req #(.N(N_TERMS)) req_i (
      .flag_i  ({ext_flag, flag_q}),
      .en_i    ({ext_en, en_vec}),
      .req_o   (req),
      .irq_n_o (irq_n)
   );

   rtc_rd_mux #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) mux_i (
      .sel_i   (rd_sel),
      .req_i   (req),
      .flags_i (flag_q),
      .vrt_i   (vrt_in),
      .data_o  (rd_data)
   );

   // pin versus flag and enable state
   logic any_term;
   assign any_term = (|(flag_q & en_vec)) || (|(ext_flag & ext_en));

   assert_irq_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      any_term |-> !irq_n);
   assert_irq_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_term |-> irq_n);
   assert_status_pad_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_STATUS) |-> (rd_data[DATA_W-NUM_EVT-2:0] == '0));
   assert_batt_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_BATT) |-> (rd_data[DATA_W-2:0] == '0 && rd_data[DATA_W-1] == vrt_in));
   assert_batt_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_sel == SEL_BATT) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: tb/rtc_irq_status_tb_top.sv
module rtc_irq_status_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
   logic       en_periodic = 0, en_alarm = 0, en_update = 0;
   logic [2:0] ext_flag = '0, ext_en = '0;
   logic       vrt_in = 0, rd_en = 0, rd_sel = 0;
   logic [7:0] rd_data;
   logic       irq_n;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rtc_irq_status dut_i (
      .clk(clk), .rst_n(rst_n),
      .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
      .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
      .ext_flag(ext_flag), .ext_en(ext_en), .vrt_in(vrt_in),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n)
   );

   // {evt p,a,u ; en p,a,u ; ext_flag ; ext_en ; expected {req,p,a,u}}
   localparam logic [15:0] VEC [8] = '{
      {3'b100, 3'b000, 3'b000, 3'b000, 4'b0100},
      {3'b100, 3'b100, 3'b000, 3'b000, 4'b1100},
      {3'b010, 3'b101, 3'b000, 3'b000, 4'b0010},
      {3'b001, 3'b001, 3'b000, 3'b000, 4'b1001},
      {3'b000, 3'b111, 3'b101, 3'b010, 4'b0000},
      {3'b000, 3'b000, 3'b101, 3'b001, 4'b1000},
      {3'b111, 3'b000, 3'b111, 3'b000, 4'b0111},
      {3'b011, 3'b010, 3'b010, 3'b010, 4'b1011}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      rd_sel = 0; rd_en = 1;
      @(negedge clk);
      rd_en = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      check("R9 reset status", rd_data, 8'h00);
      check("R9 reset irq_n", {7'd0, irq_n}, 8'h01);
      rst_n = 1;

      // table walk: R1 R2 R3 R4
      foreach (VEC[k]) begin
         @(negedge clk);
         {evt_periodic, evt_alarm, evt_update} = VEC[k][15:13];
         {en_periodic, en_alarm, en_update}    = VEC[k][12:10];
         ext_flag = VEC[k][9:7];
         ext_en   = VEC[k][6:4];
         @(negedge clk);
         {evt_periodic, evt_alarm, evt_update} = 3'b000;
         #1;
         check("R1 R2 R4 vector status", rd_data, {VEC[k][3:0], 4'h0});
         check("R3 vector irq_n", {7'd0, irq_n}, {7'd0, ~VEC[k][3]});
         clear_all();
         ext_flag = '0; ext_en = '0;
         {en_periodic, en_alarm, en_update} = 3'b000;
      end

      // R5: read returns pre-clear value, clear after the edge
      @(negedge clk); evt_periodic = 1;
      @(negedge clk); evt_periodic = 0; rd_en = 1; rd_sel = 0;
      #1 check("R5 pre-clear read", rd_data, 8'h40);
      @(negedge clk); rd_en = 0;
      #1 check("R5 cleared after edge", rd_data, 8'h00);

      // R6: set wins over clear in the same cycle
      @(negedge clk); evt_periodic = 1;
      @(negedge clk); evt_periodic = 0; evt_alarm = 1; rd_en = 1;
      @(negedge clk); evt_alarm = 0; rd_en = 0;
      #1 check("R6 set beats clear", rd_data, 8'h20);
      clear_all();

      // R3: dropping the enable releases irq_n at once, flag remains
      @(negedge clk); en_update = 1; evt_update = 1;
      @(negedge clk); evt_update = 0;
      #1 check("R3 irq asserted", {7'd0, irq_n}, 8'h00);
      en_update = 0;
      #1 check("R3 irq released on enable drop", {7'd0, irq_n}, 8'h01);
      check("R3 flag kept", rd_data, 8'h10);

      // R8: battery byte, read clears nothing
      @(negedge clk); rd_sel = 1; vrt_in = 1; rd_en = 1;
      #1 check("R8 battery vrt=1", rd_data, 8'h80);
      @(negedge clk); rd_en = 0; vrt_in = 0;
      #1 check("R8 battery vrt=0", rd_data, 8'h00);
      rd_sel = 0;
      #1 check("R8 flags kept after battery read", rd_data, 8'h10);
      clear_all();

      // R7: extended request survives a status read
      @(negedge clk); ext_flag = 3'b001; ext_en = 3'b001; rd_en = 1;
      @(negedge clk); rd_en = 0;
      #1 check("R7 ext irq after read", {7'd0, irq_n}, 8'h00);
      check("R7 ext status", rd_data, 8'h80);
      ext_flag = '0; ext_en = '0;

      // R9: reset mid-run clears flags
      @(negedge clk); evt_alarm = 1; en_alarm = 1;
      @(negedge clk); evt_alarm = 0;
      rst_n = 0;
      #1 check("R9 reset clears flags", rd_data, 8'h00);
      check("R9 reset releases irq_n", {7'd0, irq_n}, 8'h01);
      @(negedge clk); rst_n = 1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule